// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects single-bit interrupt events from eleven second-level register groups and folds them into one master register. The groups are four engine groups, three display pipes, a port group, a miscellaneous group, a south-bridge (PCH) group and a power-unit group. Each group holds a mask, a latched identity word and an enable word, and it also exposes a read-only view of its raw event inputs.

An event arrives as a group index and a bit position. It is remembered in the identity word only when that bit is unmasked. Software clears identity bits by writing ones to them. Each group's identity AND enable result drives one or two master summary bits. A global enable bit in the master register gates a single-cycle message-signalled interrupt pulse.

The pulse is produced on each re-evaluation that finds the global enable set and some summary bit set. A re-evaluation follows every event, every mask or enable write and every master write.

Top module: `irq_hier_ctrl`

## Requirements
- R1: Register map (byte addresses, word aligned; addresses with bits 1:0 nonzero are not decoded): group g sits at g*0x10, with raw status at +0x0, mask at +0x4, identity at +0x8 and enable at +0xC. Group indices are 0..3 for engines 0..3, 4..6 for pipes A..C, 7 for port, 8 for misc, 9 for PCH and 10 for the power unit. The master register is at 0x100. Read data and `rd_valid` appear one cycle after the read request.
- R2: An event on group g, bit b sets identity bit b only when mask bit b is 0. A masked event is dropped and is not latched when the mask is later cleared.
- R3: A write to an identity word clears each bit written as 1 and leaves bits written as 0 unchanged.
- R4: If an event and a clearing write hit the same identity bit in the same cycle, the bit ends up set.
- R5: Master bit k is 1 when (identity AND enable) of its source group, ANDed with its slice, is nonzero. The sources are: bit 0 engine0[15:0], bit 1 engine0[31:16], bit 2 engine1[15:0], bit 3 engine1[31:16], bit 4 engine2[15:0], bit 6 engine3[15:0], bits 16/17/18 pipes A/B/C, bit 20 port, bit 22 misc, bit 23 PCH, bit 30 power unit (all full words). Every other bit below 31 reads 0.
- R6: Only master bit 31 (global enable) is writable; writes to master bits 30:0 have no effect.
- R7: `irq_pulse` is high for one cycle, two cycles after the clock edge that takes an event or a mask, enable or master write, when master bit 31 is 1 and some master bit 30:0 is 1 at that point. It is never a level.
- R8: A write to an identity word updates the master summary but does not by itself produce a pulse.
- R9: After reset every mask word is all ones, every identity and enable word is zero, and the master register is zero.
- R10: A read of a group's status word returns that group's current `raw_status` slice, without latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event strobe |
| ev_group | input | 4 | Group index of the event |
| ev_bit | input | 5 | Bit position of the event |
| raw_status | input | 352 | Raw event inputs, 32 bits per group, group 0 lowest |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| irq_pulse | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit address and a master register at 0x100. With these values every one of the eleven groups and the master register can be reached on the bus. The bench exercises each master slice, including the split halves of engine groups 0 and 1 and the unmapped upper half of engine group 2. It also drives an event and a clearing write into the same identity bit in one cycle, and it checks that an identity write alone produces no pulse.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
  localparam int NUM_GROUPS = 11;
  localparam int WORD_W     = 32;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_IDENT  = 2'd2,
    REG_ENABLE = 2'd3
  } reg_sel_e;

  // Source group of each master summary bit; -1 marks an unused bit.
  function automatic int slot_group(input int b);
    case (b)
      0, 1:    return 0;
      2, 3:    return 1;
      4:       return 2;
      6:       return 3;
      16:      return 4;
      17:      return 5;
      18:      return 6;
      20:      return 7;
      22:      return 8;
      23:      return 9;
      30:      return 10;
      default: return -1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] slot_slice(input int b);
    case (b)
      0, 2, 4, 6: return 32'h0000_FFFF;
      1, 3:       return 32'hFFFF_0000;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/irq_group.sv
module irq_group
  import irq_hier_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_hit,
  input  logic [$clog2(W)-1:0] ev_bit,
  input  logic                 wr_mask,
  input  logic                 wr_ident,
  input  logic                 wr_en,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         mask_q,
  output logic [W-1:0]         ident_q,
  output logic [W-1:0]         en_q,
  output logic [W-1:0]         contrib
);
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    if (ev_hit && !mask_q[ev_bit]) set_vec[ev_bit] = 1'b1;
    clr_vec = wr_ident ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      ident_q <= '0;
      en_q    <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_en)   en_q   <= wdata;
      ident_q <= (ident_q & ~clr_vec) | set_vec;
    end
  end

  assign contrib = ident_q & en_q;

  p_reset_vals_r9: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && ident_q == '0 && en_q == '0));
  p_latch_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_hit && !mask_q[ev_bit]) |=> ident_q[$past(ev_bit)]);
  p_drop_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_hit && mask_q[ev_bit]) |=> ((ident_q & ~$past(ident_q)) == '0));
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ident && !ev_hit) |=> ((ident_q & $past(wdata)) == '0));
endmodule

// File: rtl/irq_fold.sv
module irq_fold
  import irq_hier_pkg::*;
#(
  parameter int NG = NUM_GROUPS,
  parameter int W  = WORD_W
) (
  input  logic [NG-1:0][W-1:0] contrib,
  output logic [W-2:0]         summary
);
  for (genvar b = 0; b < W - 1; b++) begin : g_slot
    if (slot_group(b) >= 0 && slot_group(b) < NG) begin : g_map
      assign summary[b] = |(contrib[slot_group(b)] & slot_slice(b));
    end else begin : g_none
      assign summary[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import irq_hier_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int MASTER_ADDR = 'h100,
  parameter int NG          = NUM_GROUPS,
  parameter int W           = WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid,
  input  logic [3:0]           ev_group,
  input  logic [4:0]           ev_bit,
  input  logic [NG*W-1:0]      raw_status,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [W-1:0]         bus_wdata,
  output logic [W-1:0]         bus_rdata,
  output logic                 rd_valid,
  output logic                 irq_pulse
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]    grp_idx;
  reg_sel_e            reg_sel;
  logic                aligned, master_hit, grp_hit;
  logic                wr_master, wr_any_mask, wr_any_en, wr_any_ident;
  logic [NG-1:0]       sel_g;
  logic [NG-1:0][W-1:0] mask_v, ident_v, en_v, contrib_v;
  logic [W-2:0]        summary;
  logic                master_en_q;
  logic                eval_q;

  assign grp_idx    = bus_addr[ADDR_W-1:4];
  assign reg_sel    = reg_sel_e'(bus_addr[3:2]);
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign master_hit = aligned && (bus_addr == ADDR_W'(MASTER_ADDR));
  assign grp_hit    = aligned && !master_hit && (grp_idx < IDX_W'(NG));
  assign wr_master  = bus_en && bus_we && master_hit;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic hit_ev;
    assign sel_g[g] = bus_en && bus_we && grp_hit && (grp_idx == IDX_W'(g));
    assign hit_ev   = ev_valid && (ev_group == 4'(g));
    irq_group #(.W(W)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .ev_hit  (hit_ev),
      .ev_bit  (ev_bit),
      .wr_mask (sel_g[g] && reg_sel == REG_MASK),
      .wr_ident(sel_g[g] && reg_sel == REG_IDENT),
      .wr_en   (sel_g[g] && reg_sel == REG_ENABLE),
      .wdata   (bus_wdata),
      .mask_q  (mask_v[g]),
      .ident_q (ident_v[g]),
      .en_q    (en_v[g]),
      .contrib (contrib_v[g])
    );
  end

  assign wr_any_mask  = (|sel_g) && reg_sel == REG_MASK;
  assign wr_any_en    = (|sel_g) && reg_sel == REG_ENABLE;
  assign wr_any_ident = (|sel_g) && reg_sel == REG_IDENT;

  irq_fold #(.NG(NG), .W(W)) u_fold (
    .contrib(contrib_v),
    .summary(summary)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en_q <= 1'b0;
      eval_q      <= 1'b0;
      irq_pulse   <= 1'b0;
      bus_rdata   <= '0;
      rd_valid    <= 1'b0;
    end else begin
      if (wr_master) master_en_q <= bus_wdata[W-1];
      eval_q    <= (ev_valid && ev_group < 4'(NG)) || wr_any_mask || wr_any_en || wr_master;
      irq_pulse <= eval_q && master_en_q && (|summary);
      rd_valid  <= bus_en && !bus_we;
      if (bus_en && !bus_we) begin
        bus_rdata <= '0;
        if (master_hit) begin
          bus_rdata <= {master_en_q, summary};
        end else if (grp_hit) begin
          case (reg_sel)
            REG_STATUS: bus_rdata <= raw_status[grp_idx*W +: W];
            REG_MASK:   bus_rdata <= mask_v[grp_idx];
            REG_IDENT:  bus_rdata <= ident_v[grp_idx];
            default:    bus_rdata <= en_v[grp_idx];
          endcase
        end
      end
    end
  end

  p_pulse_source_r7: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(|summary));
  p_idwr_no_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_any_ident && !ev_valid && !eval_q) |=> ##1 !irq_pulse);
  p_master_ro_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_master && !ev_valid && !(|sel_g)) |=> (summary == $past(summary)));
endmodule

// File: tb/sim_irq_hier_ctrl.sv
module sim_irq_hier_ctrl;
  localparam int NG = 11;
  logic clk = 0, rst = 1;
  logic ev_valid = 0;
  logic [3:0] ev_group = 0;
  logic [4:0] ev_bit = 0;
  logic [NG*32-1:0] raw_status = '0;
  logic bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rd_valid, irq_pulse;

  irq_hier_ctrl u0 (.*);

  always #10ns clk = ~clk;

  int n_checks = 0, n_errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] m_mask[NG], m_id[NG], m_en[NG];
  logic m_men = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data against queued expectations.
  always @(negedge clk) begin
    if (rd_valid) begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(bus_rdata === e, t, bus_rdata, e);
    end
  end

  // Bench model of the master word, written from the R5 table.
  function automatic logic [31:0] exp_master();
    logic [31:0] r = '0;
    logic [31:0] c[NG];
    for (int g = 0; g < NG; g++) c[g] = m_id[g] & m_en[g];
    r[0]  = |c[0][15:0];  r[1] = |c[0][31:16];
    r[2]  = |c[1][15:0];  r[3] = |c[1][31:16];
    r[4]  = |c[2][15:0];  r[6] = |c[3][15:0];
    r[16] = |c[4]; r[17] = |c[5]; r[18] = |c[6];
    r[20] = |c[7]; r[22] = |c[8]; r[23] = |c[9]; r[30] = |c[10];
    r[31] = m_men;
    return r;
  endfunction

  function automatic bit exp_pulse();
    logic [31:0] m = exp_master();
    return m_men && (|m[30:0]);
  endfunction

  function automatic logic [11:0] ra(input int g, input int off);
    return 12'(g * 16 + off);
  endfunction

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0;
    @(negedge clk);
  endtask

  // Write, keep the model in step, and return the pulse seen two edges later.
  task automatic wr(input logic [11:0] a, input logic [31:0] d, output bit p);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == 12'h100) m_men = d[31];
    else if (a[3:2] == 2'd1) m_mask[a[11:4]] = d;
    else if (a[3:2] == 2'd2) m_id[a[11:4]] &= ~d;
    else if (a[3:2] == 2'd3) m_en[a[11:4]] = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
    @(negedge clk); p = irq_pulse;
  endtask

  task automatic ev(input int g, input int b, output bit p);
    ev_valid = 1; ev_group = 4'(g); ev_bit = 5'(b);
    if (!m_mask[g][b]) m_id[g][b] = 1'b1;
    @(negedge clk); ev_valid = 0;
    @(negedge clk); p = irq_pulse;
  endtask

  initial begin
    bit p;
    for (int g = 0; g < NG; g++) begin m_mask[g] = '1; m_id[g] = '0; m_en[g] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(irq_pulse === 1'b0, "R9 pulse low after reset", {31'b0, irq_pulse}, 0);
    rd(ra(0, 4), 32'hFFFF_FFFF, "R9 mask reset");
    rd(ra(5, 8), 32'h0, "R9 identity reset");
    rd(ra(9, 12), 32'h0, "R9 enable reset");
    rd(12'h100, 32'h0, "R9 master reset");

    raw_status[2*32 +: 32] = 32'hA5A5_0F0F;
    rd(ra(2, 0), 32'hA5A5_0F0F, "R10 status raw read");
    raw_status[2*32 +: 32] = 32'h1234_5678;
    rd(ra(2, 0), 32'h1234_5678, "R10 status follows input");

    ev(0, 3, p);
    rd(ra(0, 8), 32'h0, "R2 masked event dropped");
    wr(ra(0, 4), 32'h0, p);
    rd(ra(0, 8), 32'h0, "R2 no latch after unmask");
    rd(ra(0, 4), 32'h0, "R1 mask readback");

    wr(12'h100, 32'hFFFF_FFFF, p);
    chk(p == exp_pulse(), "R7 master write no source", {31'b0, p}, {31'b0, exp_pulse()});
    rd(12'h100, 32'h8000_0000, "R6 master read-only bits");
    wr(ra(0, 12), 32'hFFFF_FFFF, p);
    ev(0, 3, p);
    chk(p === 1'b1, "R7 pulse on event", {31'b0, p}, 1);
    @(negedge clk);
    chk(irq_pulse === 1'b0, "R7 pulse is one cycle", {31'b0, irq_pulse}, 0);
    rd(ra(0, 8), 32'h0000_0008, "R2 unmasked latch");
    rd(12'h100, exp_master(), "R5 engine0 low half");
    ev(0, 20, p);
    rd(12'h100, exp_master(), "R5 engine0 high half");

    wr(ra(0, 8), 32'h0000_0008, p);
    chk(p === 1'b0, "R8 identity write no pulse", {31'b0, p}, 0);
    rd(ra(0, 8), 32'h0010_0000, "R3 write-one-to-clear");
    rd(12'h100, exp_master(), "R8 summary updated by clear");

    ev_valid = 1; ev_group = 0; ev_bit = 20;
    bus_en = 1; bus_we = 1; bus_addr = ra(0, 8); bus_wdata = 32'h0010_0000;
    @(negedge clk); ev_valid = 0; bus_en = 0; bus_we = 0;
    @(negedge clk);
    rd(ra(0, 8), 32'h0010_0000, "R4 event beats clear");

    for (int g = 1; g < NG; g++) begin
      wr(ra(g, 4), 32'h0, p);
      wr(ra(g, 12), 32'hFFFF_FFFF, p);
    end
    ev(2, 16, p);
    rd(12'h100, exp_master(), "R5 engine2 high half unmapped");
    ev(1, 17, p);  rd(12'h100, exp_master(), "R5 engine1 high half");
    ev(1, 2, p);   rd(12'h100, exp_master(), "R5 engine1 low half");
    ev(2, 0, p);   rd(12'h100, exp_master(), "R5 engine2 low half");
    ev(3, 5, p);   rd(12'h100, exp_master(), "R5 engine3 low half");
    for (int g = 4; g < NG; g++) begin
      ev(g, 31, p);
      chk(p == exp_pulse(), "R7 pulse per group event", {31'b0, p}, {31'b0, exp_pulse()});
      rd(12'h100, exp_master(), "R5 full-word group");
    end
    rd(ra(7, 8), 32'h8000_0000, "R1 port identity location");

    wr(ra(10, 12), 32'h0, p);
    chk(p === 1'b1, "R7 enable write re-evaluates", {31'b0, p}, 1);
    rd(12'h100, exp_master(), "R5 enable gates group");

    wr(12'h100, 32'h7FFF_FFFF, p);
    chk(p === 1'b0, "R7 global enable off", {31'b0, p}, 0);
    rd(12'h100, exp_master(), "R6 writes to low bits ignored");
    ev(4, 1, p);
    chk(p === 1'b0, "R7 gated event no pulse", {31'b0, p}, 0);
    wr(12'h100, 32'h8000_0000, p);
    chk(p === 1'b1, "R7 master enable re-evaluates", {31'b0, p}, 1);
    wr(ra(5, 4), 32'hFFFF_FFFF, p);
    chk(p === 1'b1, "R7 mask write re-evaluates", {31'b0, p}, 1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule